// File: doc/BRIEF.md
# Serial DAC Input Register Interface

This block is the digital front end of a 12-bit serial-input converter. A host frames a 16-bit write by pulling an active-low frame line low. It then presents one data bit per falling edge of a bit clock, most significant bit first. Once the sixteenth falling edge arrives, the block loads a 12-bit code register and a 2-bit mode field. It also pulses a one-cycle load strobe. If the frame line rises before that edge, the partial word is thrown away and nothing changes.

The bit clock, frame line and data line are not used as clocks. They are sampled into the system clock domain through two-stage synchronisers, and the falling edges of the bit clock are found there. The mode field is decoded into one flag per output state: normal drive, 5k pull-down, 100k pull-down and high impedance. A separate flag is set whenever any of the three powered-down states is selected.

Top module: `dac_frame_rx`

## Requirements
- R1: While the frame line is low, each falling edge of the bit clock shifts in one data bit, with the first bit of the frame taken as frame bit 15 (most significant first).
- R2: On the 16th falling edge of a frame, the code output takes frame bits 11:0 and the mode output takes frame bits 13:12.
- R3: If the frame line rises after fewer than 16 falling edges, the code, mode and flags stay unchanged and no load strobe is produced. The next frame starts from an empty shift register.
- R4: After reset, the code is 0, the mode is 00, run_normal is 1 and pd_any is 0.
- R5: The mode is decoded as follows: 00 sets run_normal, 01 sets term_5k, 10 sets term_100k and 11 sets term_hiz. Exactly one of these four flags is high at any time. pd_any is high for every nonzero mode.
- R6: Frame bits 15:14 have no effect on any output.
- R7: Falling edges after the 16th within the same low period of the frame line have no effect. Only a new frame, with the line going high and then low again, can load again.
- R8: load_stb is high for exactly one system clock cycle per completed frame, and code and mode change only in a cycle where load_stb is high.
- R9: A commit becomes visible at the third rising system clock edge after the 16th falling edge of the bit clock reaches the input pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_clk | input | 1 | Serial bit clock (asynchronous) |
| frame_n | input | 1 | Active-low frame line (asynchronous) |
| sdata | input | 1 | Serial data, most significant bit first |
| code | output | 12 | Current converter code |
| mode | output | 2 | Current mode field |
| run_normal | output | 1 | Normal drive selected (mode 00) |
| term_5k | output | 1 | 5k pull-down selected (mode 01) |
| term_100k | output | 1 | 100k pull-down selected (mode 10) |
| term_hiz | output | 1 | High-impedance output selected (mode 11) |
| pd_any | output | 1 | Any powered-down mode selected |
| load_stb | output | 1 | One-cycle pulse when a frame commits |

## Verification
Every result depends on a bit-clock fall that has to pass through two synchroniser flops and one edge-history flop. The code, mode, flags and strobe therefore change at the third rising clock edge after the bench drives the final fall. The bench drives all inputs just after a falling clock edge and holds each level for three cycles, so every level is seen cleanly. On the 16th fall of every frame, it samples at the falling edge two cycles later, expecting the old values and no strobe. It samples again one cycle after that, expecting the new values and the strobe. All other checks are made once a frame has closed and the design has had several idle cycles. Strobes are counted at falling clock edges.

// File: rtl/dac_frame_rx.sv
module dac_frame_rx #(
  parameter int CODE_W      = 12,
  parameter int FRAME_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_clk,
  input  logic              frame_n,
  input  logic              sdata,
  output logic [CODE_W-1:0] code,
  output logic [1:0]        mode,
  output logic              run_normal,
  output logic              term_5k,
  output logic              term_100k,
  output logic              term_hiz,
  output logic              pd_any,
  output logic              load_stb
);
  localparam int PAYLOAD_W = CODE_W + 2;
  localparam int CNT_W     = $clog2(FRAME_W + 1);

  logic [SYNC_STAGES-1:0] bclk_q, frm_q, dat_q;
  logic                   bclk_last;
  logic [CNT_W-1:0]       cnt;
  logic [PAYLOAD_W-2:0]   sr;
  logic [PAYLOAD_W-1:0]   nxt;
  logic                   fall, in_frame, bit_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q    <= '0;
      frm_q     <= '1;
      dat_q     <= '0;
      bclk_last <= 1'b0;
    end else begin
      bclk_q    <= {bclk_q[SYNC_STAGES-2:0], bit_clk};
      frm_q     <= {frm_q[SYNC_STAGES-2:0], frame_n};
      dat_q     <= {dat_q[SYNC_STAGES-2:0], sdata};
      bclk_last <= bclk_q[SYNC_STAGES-1];
    end
  end

  assign fall     = bclk_last & ~bclk_q[SYNC_STAGES-1];
  assign in_frame = ~frm_q[SYNC_STAGES-1];
  assign bit_s    = dat_q[SYNC_STAGES-1];
  assign nxt      = {sr, bit_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      sr       <= '0;
      code     <= '0;
      mode     <= 2'b00;
      load_stb <= 1'b0;
    end else begin
      load_stb <= 1'b0;
      if (!in_frame) begin
        cnt <= '0;
        sr  <= '0;
      end else if (fall && cnt < CNT_W'(FRAME_W)) begin
        sr  <= nxt[PAYLOAD_W-2:0];
        cnt <= cnt + 1'b1;
        if (cnt == CNT_W'(FRAME_W - 1)) begin
          code     <= nxt[CODE_W-1:0];
          mode     <= nxt[PAYLOAD_W-1:CODE_W];
          load_stb <= 1'b1;
        end
      end
    end
  end

  assign run_normal = (mode == 2'b00);
  assign term_5k    = (mode == 2'b01);
  assign term_100k  = (mode == 2'b10);
  assign term_hiz   = (mode == 2'b11);
  assign pd_any     = |mode;
endmodule

module dac_frame_rx_chk #(
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] code,
  input logic [1:0]        mode,
  input logic              run_normal,
  input logic              term_5k,
  input logic              term_100k,
  input logic              term_hiz,
  input logic              pd_any,
  input logic              load_stb
);
  a_r8_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> !load_stb);

  a_r8_code_needs_stb: assert property (@(posedge clk) disable iff (!rst_n)
    (code != $past(code)) |-> load_stb);

  a_r8_mode_needs_stb: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != $past(mode)) |-> load_stb);

  a_r5_one_state: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({run_normal, term_5k, term_100k, term_hiz}));

  a_r5_pd_excl: assert property (@(posedge clk) disable iff (!rst_n)
    pd_any != run_normal);
endmodule

bind dac_frame_rx dac_frame_rx_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .code(code), .mode(mode),
  .run_normal(run_normal), .term_5k(term_5k), .term_100k(term_100k),
  .term_hiz(term_hiz), .pd_any(pd_any), .load_stb(load_stb)
);

// File: tb/sim_dac_frame_rx.sv
module sim_dac_frame_rx;
  logic clk = 0, rst_n = 0, bit_clk = 0, frame_n = 1, sdata = 0;
  logic [11:0] code;
  logic [1:0]  mode;
  logic run_normal, term_5k, term_100k, term_hiz, pd_any, load_stb;

  int checks = 0, fails = 0, stb_cnt = 0;
  logic [11:0] exp_code = 0;
  logic [1:0]  exp_mode = 0;

  always #10 clk = ~clk;

  dac_frame_rx u0 (.clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .frame_n(frame_n),
    .sdata(sdata), .code(code), .mode(mode), .run_normal(run_normal),
    .term_5k(term_5k), .term_100k(term_100k), .term_hiz(term_hiz),
    .pd_any(pd_any), .load_stb(load_stb));

  always @(negedge clk) if (load_stb) stb_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_outputs(input string req);
    chk(req, {20'd0, code}, {20'd0, exp_code});
    chk(req, {30'd0, mode}, {30'd0, exp_mode});
    // R5: one flag per mode value, pd_any for any nonzero mode
    chk("R5", {27'd0, run_normal, term_5k, term_100k, term_hiz, pd_any},
        {27'd0, exp_mode == 2'b00, exp_mode == 2'b01, exp_mode == 2'b10,
         exp_mode == 2'b11, exp_mode != 2'b00});
  endtask

  // sends bits[n-1] first down to bits[0]
  task automatic send(input logic [31:0] bits, input int n);
    int s0 = stb_cnt;
    logic [15:0] w;
    @(negedge clk) frame_n = 0;
    repeat (3) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      sdata = bits[i]; bit_clk = 1;
      repeat (3) @(negedge clk);
      bit_clk = 0;
      if (i == n - 16) begin
        repeat (2) @(negedge clk);
        // R9: not yet visible two edges after the fall
        chk("R9", {31'd0, load_stb}, 32'd0);
        chk("R9", {20'd0, code}, {20'd0, exp_code});
        @(negedge clk);
        w = bits[i +: 16];
        exp_code = w[11:0];
        exp_mode = w[13:12];
        chk("R9", {31'd0, load_stb}, 32'd1);
        chk("R2", {20'd0, code}, {20'd0, exp_code});
      end else begin
        repeat (3) @(negedge clk);
      end
    end
    repeat (3) @(negedge clk);
    frame_n = 1;
    repeat (4) @(negedge clk);
    chk(n >= 16 ? "R8" : "R3", stb_cnt - s0, n >= 16 ? 1 : 0);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R4: reset state
    chk_outputs("R4");
    chk("R4", {31'd0, load_stb}, 32'd0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk_outputs("R4");

    // R1/R2/R5: all modes, walking-one codes plus extremes (MSB first)
    for (int m = 0; m < 4; m++) begin
      for (int b = 0; b < 14; b++) begin
        logic [11:0] c;
        c = (b < 12) ? 12'(1 << b) : (b == 12 ? 12'h000 : 12'hFFF);
        send({16'd0, 2'b00, 2'(m), c}, 16);
        chk_outputs("R1");
      end
    end

    // R6: bits 15:14 ignored
    for (int t = 0; t < 4; t++) begin
      send({16'd0, 2'(t), 2'b10, 12'hA5C}, 16);
      chk_outputs("R6");
      chk("R6", {20'd0, code}, 32'hA5C);
    end

    // R3: every short frame length leaves state untouched
    send({16'd0, 16'h1357}, 16);
    for (int n = 0; n < 16; n++) begin
      send(32'hFFFF_FFFF, n);
      chk_outputs("R3");
      chk("R3", {20'd0, code}, 32'h357);
    end
    // R3: fresh frame after an aborted one starts empty
    send(32'h0000_3ABC, 7);
    send({16'd0, 16'h2468}, 16);
    chk_outputs("R3");
    chk("R3", {30'd0, mode}, 32'd2);

    // R7: extra falls beyond the 16th ignored
    for (int n = 17; n <= 20; n++) begin
      send(32'h000F_FFFF ^ (32'h5A5A5 << (n - 17)), n);
      chk_outputs("R7");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule